// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers five interrupt sources for a small 8-bit processor core and chooses which one the core should service next. The sources are two external request pins (active low), two timer overflow events and one combined serial-port request (receive or transmit). Software writes a priority register, an enable register and a control register. The control register holds the timer run bits, the trigger type of each external pin and the request flags.

The external pins are synchronized and watched for a falling edge or a low level, as each pin's type bit selects. Each pending, enabled request falls into one of two levels according to its priority bit. A high-level request wins over any low-level one. Within a level, a fixed polling order picks the winner. The winner is latched into a vector request carrying a fixed vector address, and the request is held until the core acknowledges it. On acknowledge the block records the handler's level as in service. It also clears the winner's flag if that source is a timer or an edge-mode external input. A return strobe retires the most recent (highest) in-service level. This lets a high-level handler nest inside a low-level one, and blocks every other case of preemption.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, vec_req is 0 and prio_q, en_q and ctrl_q all read 0. Both pins are idle high and both types are level mode.
- R2: Register select 0 is the priority register. Bits 4..0 map to sources external 0 (bit 0), timer 0 (bit 1), external 1 (bit 2), timer 1 (bit 3) and serial (bit 4). A 1 puts the source in the high level. Bits 7..5 read 0. Any pending high-level request wins over every low-level request.
- R3: Among pending requests of one level, the winner is the first in the order external 0, timer 0, external 1, timer 1, serial.
- R4: While a high-level handler is in service, no request is issued. While only a low-level handler is in service, only high-level requests are issued.
- R5: Register select 1 is the enable register. Bit 7 is the global enable and bits 4..0 are per-source enables in the R2 bit order. A request is eligible only when both its own bit and the global bit are 1.
- R6: The vector address is 0x0003 + 8 × (source index in the R3 order). Once raised, vec_req and vec_addr hold until ack is sampled high, and vec_req is 0 in the next cycle. An ack while vec_req is 0 has no effect.
- R7: A one-cycle tmr_ovf[i] pulse sets the timer i flag. Acknowledging a timer vector clears that flag. If an overflow falls in the same cycle as that acknowledge, the flag stays set.
- R8: With a type bit of 1 (edge mode), a high-to-low transition of the synchronized pin sets the external flag. Acknowledging its vector clears the flag. A rising transition sets nothing.
- R9: With a type bit of 0 (level mode), the external request and its ctrl_q flag bit equal the inverted synchronized pin, with no latching.
- R10: The serial request is ser_rx OR ser_tx. It is not cleared by acknowledge and is issued again after the handler returns while an input stays high.
- R11: reti clears the high in-service level if it is set, and otherwise the low one.
- R12: Register select 2 is the control register, bit 7 down to bit 0: timer 1 flag, timer 1 run, timer 0 flag, timer 0 run, external 1 flag, external 1 type, external 0 flag, external 0 type. A write loads all stored bits, and ctrl_q reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 priority, 1 enable, 2 control |
| cfg_wdata | input | REG_W | Write data |
| prio_q | output | REG_W | Priority register readback |
| en_q | output | REG_W | Enable register readback |
| ctrl_q | output | REG_W | Control register readback |
| ext_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx | input | 1 | Serial receive request |
| ser_tx | input | 1 | Serial transmit request |
| vec_req | output | 1 | Vector request to the core |
| vec_addr | output | VEC_W | Vector address of the pending request |
| ack | input | 1 | Core accepts the vector |
| reti | input | 1 | Return from interrupt |

## Verification
The collision that matters is a timer overflow landing in the same cycle as the acknowledge that clears that timer's flag. The bench drives tmr_ovf and ack in one cycle and expects the flag to read 1 afterwards, so the new event is not lost. A sweep covers every priority setting against every combination of pending sources. The bench computes each winner arithmetically and also checks that acknowledging clears only the flags that hardware should clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int NSRC = 5;
   localparam int IDXW = 3;

   typedef enum logic [IDXW-1:0] {
      SRC_EX0 = 3'd0,
      SRC_TM0 = 3'd1,
      SRC_EX1 = 3'd2,
      SRC_TM1 = 3'd3,
      SRC_SER = 3'd4
   } src_e;

   typedef enum logic [1:0] {
      SEL_PRIO = 2'd0,
      SEL_EN   = 2'd1,
      SEL_CTRL = 2'd2
   } sel_e;

   function automatic int vec_of(int base, int step, int idx);
      return base + idx * step;
   endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic low_now,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad
         $error("irq_pin_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '1;
         last  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], pin_n};
         last  <= chain[STAGES-1];
      end
   end

   assign low_now = ~chain[STAGES-1];
   assign fall    = last & ~chain[STAGES-1];

   AST_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R8
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N = 5,
   parameter int W = 3
) (
   input  logic [N-1:0] req,
   output logic [W-1:0] idx,
   output logic         hit
);
   generate
      if (N > (1 << W)) begin : g_bad
         $error("irq_pick index too narrow");
      end
   endgenerate

   always_comb begin
      idx = '0;
      hit = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = W'(i);
            hit = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int REG_W       = 8,
   parameter int VEC_W       = 16,
   parameter int VEC_BASE    = 3,
   parameter int VEC_STEP    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] prio_q,
   output logic [REG_W-1:0] en_q,
   output logic [REG_W-1:0] ctrl_q,
   input  logic [1:0]       ext_n,
   input  logic [1:0]       tmr_ovf,
   input  logic             ser_rx,
   input  logic             ser_tx,
   output logic             vec_req,
   output logic [VEC_W-1:0] vec_addr,
   input  logic             ack,
   input  logic             reti
);
   localparam int VEC_LAST = VEC_BASE + (NSRC - 1) * VEC_STEP;

   generate
      if (REG_W < 8) begin : g_bad_reg
         $error("register width below eight bits");
      end
      if (VEC_LAST >= (1 << VEC_W)) begin : g_bad_vec
         $error("vector width too narrow for the last vector");
      end
   endgenerate

   logic [NSRC-1:0] prio_r, en_src_r;
   logic            en_all_r;
   logic [1:0]      tr_r, it_r, tf_r, ie_r;
   logic [1:0]      tf_n, ie_n, it_n;
   logic [1:0]      ext_low, ext_fall, ext_req;
   logic            wr_prio, wr_en, wr_ctrl, take;
   logic [NSRC-1:0] clr_src, req, pend;
   logic [IDXW-1:0] hi_idx, lo_idx, win_idx, vec_idx;
   logic            hi_hit, lo_hit, win_hit, win_lvl, vec_lvl;
   logic            isr_hi, isr_lo;

   // pin front ends
   generate
      for (genvar g = 0; g < 2; g++) begin : g_pin
         irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n   (ext_n[g]),
            .low_now (ext_low[g]),
            .fall    (ext_fall[g])
         );
      end
   endgenerate

   assign wr_prio = cfg_we && (cfg_addr == SEL_PRIO);
   assign wr_en   = cfg_we && (cfg_addr == SEL_EN);
   assign wr_ctrl = cfg_we && (cfg_addr == SEL_CTRL);
   assign take    = vec_req && ack;

   always_comb begin
      clr_src = '0;
      if (take) clr_src[vec_idx] = 1'b1;
   end

   // flag next state: hardware set beats software write beats acknowledge clear
   always_comb begin
      it_n = wr_ctrl ? {cfg_wdata[2], cfg_wdata[0]} : it_r;
      for (int g = 0; g < 2; g++) begin
         if (tmr_ovf[g])           tf_n[g] = 1'b1;
         else if (wr_ctrl)         tf_n[g] = cfg_wdata[5 + 2 * g];
         else if (clr_src[2*g+1])  tf_n[g] = 1'b0;
         else                      tf_n[g] = tf_r[g];

         if (!it_n[g])             ie_n[g] = 1'b0;
         else if (ext_fall[g])     ie_n[g] = 1'b1;
         else if (wr_ctrl)         ie_n[g] = cfg_wdata[1 + 2 * g];
         else if (clr_src[2*g])    ie_n[g] = 1'b0;
         else                      ie_n[g] = ie_r[g];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_r   <= '0;
         en_src_r <= '0;
         en_all_r <= 1'b0;
         tr_r     <= '0;
         it_r     <= '0;
         tf_r     <= '0;
         ie_r     <= '0;
      end else begin
         if (wr_prio) prio_r <= cfg_wdata[NSRC-1:0];
         if (wr_en) begin
            en_src_r <= cfg_wdata[NSRC-1:0];
            en_all_r <= cfg_wdata[7];
         end
         if (wr_ctrl) tr_r <= {cfg_wdata[6], cfg_wdata[4]};
         it_r <= it_n;
         tf_r <= tf_n;
         ie_r <= ie_n;
      end
   end

   always_comb begin
      for (int g = 0; g < 2; g++)
         ext_req[g] = it_r[g] ? ie_r[g] : ext_low[g];
   end

   assign req  = {ser_rx | ser_tx, tf_r[1], ext_req[1], tf_r[0], ext_req[0]};
   assign pend = req & en_src_r & {NSRC{en_all_r}};

   irq_pick #(.N(NSRC), .W(IDXW)) u_pick_hi (
      .req (pend & prio_r),
      .idx (hi_idx),
      .hit (hi_hit)
   );

   irq_pick #(.N(NSRC), .W(IDXW)) u_pick_lo (
      .req (pend & ~prio_r),
      .idx (lo_idx),
      .hit (lo_hit)
   );

   // nesting gate: a high handler blocks all, a low handler blocks its own level
   always_comb begin
      win_hit = 1'b0;
      win_idx = hi_idx;
      win_lvl = 1'b1;
      if (!isr_hi) begin
         if (hi_hit) begin
            win_hit = 1'b1;
         end else if (!isr_lo && lo_hit) begin
            win_hit = 1'b1;
            win_idx = lo_idx;
            win_lvl = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_req <= 1'b0;
         vec_idx <= '0;
         vec_lvl <= 1'b0;
      end else if (!vec_req) begin
         if (win_hit) begin
            vec_req <= 1'b1;
            vec_idx <= win_idx;
            vec_lvl <= win_lvl;
         end
      end else if (ack) begin
         vec_req <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_hi <= 1'b0;
         isr_lo <= 1'b0;
      end else begin
         if (take && vec_lvl)        isr_hi <= 1'b1;
         else if (reti)              isr_hi <= 1'b0;
         if (take && !vec_lvl)       isr_lo <= 1'b1;
         else if (reti && !isr_hi)   isr_lo <= 1'b0;
      end
   end

   assign vec_addr = VEC_W'(vec_of(VEC_BASE, VEC_STEP, int'(vec_idx)));
   assign prio_q   = REG_W'(prio_r);
   assign en_q     = REG_W'({en_all_r, 2'b00, en_src_r});
   assign ctrl_q   = REG_W'({tf_r[1], tr_r[1], tf_r[0], tr_r[0],
                             ext_req[1], it_r[1], ext_req[0], it_r[0]});

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req && !ack |=> vec_req && $stable(vec_addr)); // R6
   AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req && ack |=> !vec_req); // R6
   AST_HI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      isr_hi && !vec_req |=> !vec_req); // R4
   AST_LO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      isr_lo && !vec_req |=> !vec_req || vec_lvl); // R4
   AST_TMR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[0] |=> tf_r[0]); // R7
   AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ext_fall[1] && it_n[1] |=> ie_r[1]); // R8
   AST_RETI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      reti && isr_hi && !take |=> !isr_hi && (isr_lo == $past(isr_lo))); // R11
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = 2'd0;
   logic [7:0] cfg_wdata = 8'd0;
   logic [7:0] prio_q, en_q, ctrl_q;
   logic [1:0] ext_n = 2'b11;
   logic [1:0] tmr_ovf = 2'b00;
   logic       ser_rx = 1'b0, ser_tx = 1'b0;
   logic       vec_req;
   logic [15:0] vec_addr;
   logic       ack = 1'b0, reti = 1'b0;
   int         tests = 0, fails = 0;

   always #4 clk = ~clk;

   irq_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .prio_q(prio_q), .en_q(en_q), .ctrl_q(ctrl_q),
      .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx),
      .vec_req(vec_req), .vec_addr(vec_addr), .ack(ack), .reti(reti)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic do_reti();
      @(negedge clk); reti = 1'b1;
      @(negedge clk); reti = 1'b0;
   endtask

   task automatic chk_vec(input string tag, input int exp_addr);
      chk(vec_req === 1'b1 && vec_addr == 16'(exp_addr), tag,
          {15'd0, vec_req} * 65536 + int'(vec_addr), 65536 + exp_addr);
   endtask

   function automatic int lowest(input int m);
      for (int i = 0; i < 5; i++) if (m[i]) return i;
      return -1;
   endfunction

   function automatic int flag_bit(input int src);
      case (src)
         0: return 1;
         1: return 5;
         2: return 3;
         default: return 7;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk(vec_req === 1'b0, "R1 vec_req", vec_req, 0);
      chk(prio_q == 8'h00 && en_q == 8'h00, "R1 prio/en", {prio_q, en_q}, 0);
      chk(ctrl_q == 8'h00, "R1 ctrl", ctrl_q, 0);

      // R2 reserved bits read zero
      wr(0, 8'hFF);
      chk(prio_q == 8'h1F, "R2 readback", prio_q, 8'h1F);
      wr(0, 8'h00);

      // R6 ack while idle has no effect
      do_ack();
      wr(2, 8'h20);
      wr(1, 8'h82);
      idle(2);
      chk_vec("R6 ack-idle ignored", 8'h0B);
      do_ack();
      wr(1, 8'h00); do_reti(); wr(2, 8'h00);

      // R2 R3 R6 sweep over every priority setting and source combination
      for (int p = 0; p < 32; p++) begin
         for (int m = 1; m < 32; m++) begin
            int w, hm;
            logic [7:0] d;
            hm = p & m;
            w  = (hm != 0) ? lowest(hm) : lowest(m);
            d  = 8'h05;
            if (m[0]) d[1] = 1'b1;
            if (m[1]) d[5] = 1'b1;
            if (m[2]) d[3] = 1'b1;
            if (m[3]) d[7] = 1'b1;
            wr(1, 8'h00);
            wr(0, 8'(p));
            wr(2, d);
            ser_rx = m[4];
            wr(1, 8'h9F);
            idle(2);
            chk_vec($sformatf("R2 R3 R6 prio=%0h mask=%0h", p, m), 3 + 8 * w);
            do_ack();
            if (w != 4)
               chk(ctrl_q[flag_bit(w)] == 1'b0, "R7 R8 ack clears flag",
                   ctrl_q, 0);
            wr(1, 8'h00);
            wr(2, 8'h00);
            ser_rx = 1'b0;
            do_reti();
         end
      end
      wr(0, 8'h00);

      // R4 R8 R11 nesting
      wr(0, 8'h04);
      wr(2, 8'h25);
      wr(1, 8'h9F);
      idle(2);
      chk_vec("R4 low handler entry", 8'h0B);
      do_ack();
      wr(2, 8'h85);
      idle(3);
      chk(vec_req === 1'b0, "R4 same level blocked", vec_req, 0);
      ext_n[1] = 1'b0;
      idle(5);
      chk_vec("R4 high preempts low", 8'h13);
      do_ack();
      chk(ctrl_q[3] == 1'b0, "R8 edge flag cleared", ctrl_q, 0);
      wr(0, 8'h05);
      ext_n[0] = 1'b0;
      idle(5);
      chk(vec_req === 1'b0, "R4 high blocks high", vec_req, 0);
      chk(ctrl_q[1] == 1'b1, "R8 falling edge sets flag", ctrl_q, 2);
      do_reti();
      idle(2);
      chk_vec("R11 reti clears high only", 8'h03);
      do_ack();
      do_reti();
      idle(3);
      chk(vec_req === 1'b0, "R11 low still in service", vec_req, 0);
      do_reti();
      idle(2);
      chk_vec("R11 low retired", 8'h1B);
      do_ack();
      wr(1, 8'h00);
      do_reti();
      ext_n = 2'b11;
      idle(4);
      chk(ctrl_q[3] == 1'b0 && ctrl_q[1] == 1'b0, "R8 rise sets nothing", ctrl_q, 8'h05);
      wr(2, 8'h00);
      wr(0, 8'h00);

      // R9 level mode
      wr(1, 8'h81);
      ext_n[0] = 1'b0;
      idle(4);
      chk(ctrl_q[1] == 1'b1, "R9 level visible", ctrl_q, 2);
      chk_vec("R9 level request", 8'h03);
      ext_n[0] = 1'b1;
      idle(4);
      chk(ctrl_q[1] == 1'b0, "R9 not latched", ctrl_q, 0);
      chk(vec_req === 1'b1, "R6 held until ack", vec_req, 1);
      do_ack();
      wr(1, 8'h00);
      do_reti();

      // R5 enables
      wr(1, 8'h1F);
      wr(2, 8'h20);
      idle(3);
      chk(vec_req === 1'b0, "R5 global off", vec_req, 0);
      wr(1, 8'h9D);
      idle(3);
      chk(vec_req === 1'b0, "R5 source off", vec_req, 0);
      chk(en_q == 8'h9D, "R5 readback", en_q, 8'h9D);
      wr(1, 8'h82);
      idle(2);
      chk_vec("R5 source on", 8'h0B);

      // R7 overflow coincides with acknowledge
      @(negedge clk); ack = 1'b1; tmr_ovf[0] = 1'b1;
      @(negedge clk); ack = 1'b0; tmr_ovf[0] = 1'b0;
      chk(ctrl_q[5] == 1'b1, "R7 set beats ack clear", ctrl_q, 8'h20);
      chk(vec_req === 1'b0, "R6 drop after ack", vec_req, 0);
      wr(1, 8'h00);
      do_reti();
      wr(2, 8'h00);
      @(negedge clk); tmr_ovf[1] = 1'b1;
      @(negedge clk); tmr_ovf[1] = 1'b0;
      chk(ctrl_q == 8'h80, "R7 overflow sets flag", ctrl_q, 8'h80);
      wr(2, 8'h50);
      chk(ctrl_q == 8'h50, "R12 run bits and flag clear", ctrl_q, 8'h50);
      wr(2, 8'h00);

      // R10 serial stays pending
      wr(1, 8'h90);
      ser_tx = 1'b1;
      idle(2);
      chk_vec("R10 serial vector", 8'h23);
      do_ack();
      do_reti();
      idle(2);
      chk_vec("R10 not cleared by ack", 8'h23);
      do_ack();
      ser_tx = 1'b0;
      wr(1, 8'h00);
      do_reti();
      idle(3);
      chk(vec_req === 1'b0, "R10 gone after clear", vec_req, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule